// File: doc/BRIEF.md
# Wide register access collector

This block connects a 32-bit memory-mapped host port to storage that is wider than the bus. The storage holds 128-bit control registers and a table of 64-bit buffer entries. A wide value cannot arrive in one bus beat, so the host sends it as a series of dword writes. The block holds the leading dwords in a staging buffer that is tagged with their target. It writes the whole value into the register in a single cycle, and it does so only when the closing dword arrives. Software therefore never sees a wide register half updated.

Reads work in the opposite direction. Reading the lowest dword of a wide register (or of a buffer entry) copies the whole value into a shadow buffer. The remaining dwords are then read from that shadow buffer, so the host assembles a value that was captured at one moment.

Three doorbell registers in each page are dword sized. They bypass the collector: a write to one takes effect at once and leaves any collection that is in progress untouched. The address space is divided into pages of 0x2000 bytes. Each page has its own wide registers and doorbells. The buffer table exists in page 0 only.

Top module: `wreg_collector`

## Requirements
- R1: While reset is asserted, and after it, the acknowledge and read data outputs are low. Every wide register, buffer entry, doorbell, staged dword and the shadow buffer read back as zero until written.
- R2: Each request is acknowledged in the cycle after it is accepted, and requests may arrive back to back. A read returns its data in that acknowledge cycle. In every other cycle the read data is zero.
- R3: A wide register is at byte address page*0x2000 + n*16 for n below NREG (a table with a 16-byte stride). Its dword d is at byte offset 4*d. Writes to dwords 0, 1 and 2 only stage data, and the register keeps its old value. A write to dword 3 stores all 128 bits in one cycle and empties the staging buffer.
- R4: Buffer entry i is at 0x1000 + i*8 in page 0. Its lower dword is at +0 and its upper dword at +4. A lower-dword write only stages data. An upper-dword write stores all 64 bits and empties the staging buffer.
- R5: A read of dword 0 of a wide register copies all 128 bits into the shadow buffer and returns bits 31:0. Reads of dwords 1 to 3 return shadow bits [32d+31:32d], even if the register has been written since the copy. For a buffer entry, a lower-dword read loads shadow bits 63:0, and an upper-dword read returns shadow bits 63:32.
- R6: Doorbell b (b = 0, 1, 2) of page p is at p*0x2000 + 0x800 + b*16. A write to it stores the dword at once, and a read returns the stored value.
- R7: A doorbell write that arrives between the partial writes of a collection leaves the staged dwords and their tag unchanged. The collection then stores the intended value.
- R8: The staging buffer is tagged with its target. A closing write uses only the staged dwords whose tag matches its own target. The target keeps its current value in every dword that was not staged for it. A partial write to a different target discards the old staged dwords.
- R9: Wide registers and doorbells in different pages are separate storage, and buffer entries are separate from one another.
- R10: Any other address is unmapped, including the table range outside page 0, pages at or above NPAGE and doorbell offsets other than dword 0. A write to an unmapped address changes no storage and no staged data. A read from one returns zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| host_req | input | 1 | Request valid for one cycle per access |
| host_we | input | 1 | 1 = write, 0 = read |
| host_addr | input | ADDR_W | Byte address; bits 1:0 ignored |
| host_wdata | input | 32 | Write dword |
| host_ack | output | 1 | Acknowledge, one cycle after the request |
| host_rdata | output | 32 | Read dword, valid with host_ack |

## Verification
- **Acknowledge and read data:** both appear in the cycle that follows the clock edge at which the request was sampled, through exactly one register.
- **Commits:** a commit or doorbell write takes effect at that same edge, so a read issued in the very next cycle already sees it. Likewise, a shadow load is visible to a read of dword 1 issued on the next cycle.
- **How the bench samples:** the bench drives inputs on the falling edge and advances its behavioural model on the rising edge. It compares acknowledge and read data with the model on every falling edge, halfway through the cycle in which they are due.

// File: rtl/wrc_pkg.sv
`timescale 1ns/1ps
package wrc_pkg;
  localparam int unsigned DW           = 32;
  localparam int unsigned WIDE_DWORDS  = 4;
  localparam int unsigned WIDE_W       = DW * WIDE_DWORDS;
  localparam int unsigned SRAM_W       = 2 * DW;
  localparam int unsigned NSLOT        = WIDE_DWORDS - 1;
  localparam int unsigned STAGE_W      = DW * NSLOT;
  localparam int unsigned WIDE_STRIDE  = 16;
  localparam int unsigned SRAM_STRIDE  = 8;

  typedef enum logic [1:0] {
    ACC_NONE = 2'd0,
    ACC_WIDE = 2'd1,
    ACC_SRAM = 2'd2,
    ACC_BELL = 2'd3
  } acc_kind_e;
endpackage

// File: rtl/wrc_decode.sv
`timescale 1ns/1ps
module wrc_decode
  import wrc_pkg::*;
#(
  parameter int unsigned ADDR_W     = 16,
  parameter int unsigned PAGE_SHIFT = 13,
  parameter int unsigned NPAGE      = 2,
  parameter int unsigned NREG       = 4,
  parameter int unsigned NSRAM      = 8,
  parameter int unsigned NBELL      = 3,
  parameter int unsigned BELL_OFS   = 'h800,
  parameter int unsigned SRAM_OFS   = 'h1000,
  parameter int unsigned PG_W       = 1,
  parameter int unsigned IX_W       = 3
) (
  input  logic [ADDR_W-1:0] addr,
  output acc_kind_e         kind,
  output logic [PG_W-1:0]   page,
  output logic [IX_W-1:0]   idx,
  output logic [1:0]        dw
);
  logic [31:0] off;
  logic [31:0] pg;

  always_comb begin
    off  = 32'(addr[PAGE_SHIFT-1:0]);
    pg   = 32'(addr[ADDR_W-1:PAGE_SHIFT]);
    kind = ACC_NONE;
    idx  = '0;
    dw   = '0;
    page = PG_W'(pg);
    if (pg < NPAGE) begin
      if (off < NREG * WIDE_STRIDE) begin
        kind = ACC_WIDE;
        idx  = IX_W'(off / WIDE_STRIDE);
        dw   = off[3:2];
      end else if (off >= BELL_OFS && off < BELL_OFS + NBELL * WIDE_STRIDE &&
                   off[3:2] == 2'd0) begin
        kind = ACC_BELL;
        idx  = IX_W'((off - BELL_OFS) / WIDE_STRIDE);
      end else if (pg == 32'd0 && off >= SRAM_OFS &&
                   off < SRAM_OFS + NSRAM * SRAM_STRIDE) begin
        kind = ACC_SRAM;
        idx  = IX_W'((off - SRAM_OFS) / SRAM_STRIDE);
        dw   = {1'b0, off[2]};
      end
    end
  end
endmodule

// File: rtl/wrc_stage.sv
`timescale 1ns/1ps
module wrc_stage
  import wrc_pkg::*;
#(
  parameter int unsigned PG_W = 1,
  parameter int unsigned IX_W = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  acc_kind_e          kind,
  input  logic [PG_W-1:0]    page,
  input  logic [IX_W-1:0]    idx,
  input  logic [1:0]         dw,
  input  logic [DW-1:0]      wdata,
  input  logic [STAGE_W-1:0] cur_wide_lo,
  input  logic [DW-1:0]      cur_sram_lo,
  output logic               wide_we,
  output logic               sram_we,
  output logic [WIDE_W-1:0]  wide_data,
  output logic [SRAM_W-1:0]  sram_data,
  output logic [NSLOT-1:0]   stg_valid,
  output logic [STAGE_W-1:0] stg_data
);
  localparam int unsigned KEY_W = 2 + PG_W + IX_W;

  logic [KEY_W-1:0]   key_q, key_d, key_in;
  logic [NSLOT-1:0]   valid_q, valid_d;
  logic [STAGE_W-1:0] data_q, data_d;
  logic               tag_hit, is_last, is_part, stage_en;

  assign key_in  = {kind, page, idx};
  assign tag_hit = (key_q == key_in);

  // next-state
  always_comb begin
    valid_d = valid_q;
    key_d   = key_q;
    data_d  = data_q;
    wide_we = 1'b0;
    sram_we = 1'b0;
    is_last = (kind == ACC_WIDE && dw == 2'd3) || (kind == ACC_SRAM && dw == 2'd1);
    is_part = (kind == ACC_WIDE && dw != 2'd3) || (kind == ACC_SRAM && dw == 2'd0);
    stage_en = wr_en && (is_last || is_part);
    if (wr_en && is_last) begin
      wide_we = (kind == ACC_WIDE);
      sram_we = (kind == ACC_SRAM);
      valid_d = '0;
    end else if (wr_en && is_part) begin
      if (!tag_hit) valid_d = '0;
      key_d               = key_in;
      valid_d[dw]         = 1'b1;
      data_d[dw*DW +: DW] = wdata;
    end
  end

  // merge: only dwords staged for this same target are used
  for (genvar j = 0; j < NSLOT; j++) begin : g_slot
    assign wide_data[j*DW +: DW] = (tag_hit && valid_q[j]) ? data_q[j*DW +: DW]
                                                           : cur_wide_lo[j*DW +: DW];
  end
  assign wide_data[WIDE_W-1 -: DW] = wdata;
  assign sram_data = {wdata, (tag_hit && valid_q[0]) ? data_q[DW-1:0] : cur_sram_lo};

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= '0;
      key_q   <= '0;
      data_q  <= '0;
    end else if (stage_en) begin
      valid_q <= valid_d;
      key_q   <= key_d;
      data_q  <= data_d;
    end
  end

  assign stg_valid = valid_q;
  assign stg_data  = data_q;
endmodule

// File: rtl/wrc_store.sv
`timescale 1ns/1ps
module wrc_store
  import wrc_pkg::*;
#(
  parameter int unsigned NPAGE = 2,
  parameter int unsigned NREG  = 4,
  parameter int unsigned NSRAM = 8,
  parameter int unsigned NBELL = 3,
  parameter int unsigned PG_W  = 1,
  parameter int unsigned IX_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wide_we,
  input  logic              sram_we,
  input  logic              bell_we,
  input  logic [PG_W-1:0]   page,
  input  logic [IX_W-1:0]   idx,
  input  logic [WIDE_W-1:0] wide_wdata,
  input  logic [SRAM_W-1:0] sram_wdata,
  input  logic [DW-1:0]     bell_wdata,
  output logic [WIDE_W-1:0] wide_rd,
  output logic [SRAM_W-1:0] sram_rd,
  output logic [DW-1:0]     bell_rd
);
  localparam int unsigned NWIDE  = NPAGE * NREG;
  localparam int unsigned NBELLS = NPAGE * NBELL;

  logic [WIDE_W-1:0] wide_q [NWIDE];
  logic [SRAM_W-1:0] sram_q [NSRAM];
  logic [DW-1:0]     bell_q [NBELLS];
  logic [31:0]       wsel, bsel, ssel;

  assign wsel = 32'(page) * NREG  + 32'(idx);
  assign bsel = 32'(page) * NBELL + 32'(idx);
  assign ssel = 32'(idx);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NWIDE; i++) wide_q[i] <= '0;
    end else if (wide_we) begin
      for (int i = 0; i < NWIDE; i++)
        if (wsel == 32'(i)) wide_q[i] <= wide_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NSRAM; i++) sram_q[i] <= '0;
    end else if (sram_we) begin
      for (int i = 0; i < NSRAM; i++)
        if (ssel == 32'(i)) sram_q[i] <= sram_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NBELLS; i++) bell_q[i] <= '0;
    end else if (bell_we) begin
      for (int i = 0; i < NBELLS; i++)
        if (bsel == 32'(i)) bell_q[i] <= bell_wdata;
    end
  end

  always_comb begin
    wide_rd = '0;
    sram_rd = '0;
    bell_rd = '0;
    for (int i = 0; i < NWIDE; i++)  if (wsel == 32'(i)) wide_rd = wide_q[i];
    for (int i = 0; i < NSRAM; i++)  if (ssel == 32'(i)) sram_rd = sram_q[i];
    for (int i = 0; i < NBELLS; i++) if (bsel == 32'(i)) bell_rd = bell_q[i];
  end
endmodule

// File: rtl/wrc_readpath.sv
`timescale 1ns/1ps
module wrc_readpath
  import wrc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en,
  input  acc_kind_e         kind,
  input  logic [1:0]        dw,
  input  logic [WIDE_W-1:0] wide_rd,
  input  logic [SRAM_W-1:0] sram_rd,
  input  logic [DW-1:0]     bell_rd,
  output logic [DW-1:0]     rdata
);
  logic [WIDE_W-1:0] shadow_q, shadow_d;
  logic [DW-1:0]     rdata_q, rdata_d;
  logic              shadow_ld;

  // next-state
  always_comb begin
    shadow_d  = shadow_q;
    shadow_ld = 1'b0;
    rdata_d   = '0;
    if (rd_en) begin
      unique case (kind)
        ACC_WIDE: begin
          if (dw == 2'd0) begin
            shadow_d  = wide_rd;
            shadow_ld = 1'b1;
            rdata_d   = wide_rd[DW-1:0];
          end else begin
            rdata_d = shadow_q[dw*DW +: DW];
          end
        end
        ACC_SRAM: begin
          if (dw == 2'd0) begin
            shadow_d[SRAM_W-1:0] = sram_rd;
            shadow_ld            = 1'b1;
            rdata_d              = sram_rd[DW-1:0];
          end else begin
            rdata_d = shadow_q[DW +: DW];
          end
        end
        ACC_BELL: rdata_d = bell_rd;
        default:  rdata_d = '0;
      endcase
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shadow_q <= '0;
    end else if (shadow_ld) begin
      shadow_q <= shadow_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata_q <= '0;
    else        rdata_q <= rdata_d;
  end

  assign rdata = rdata_q;
endmodule

// File: rtl/wreg_collector.sv
`timescale 1ns/1ps
module wreg_collector
  import wrc_pkg::*;
#(
  parameter int unsigned ADDR_W     = 16,
  parameter int unsigned PAGE_SHIFT = 13,
  parameter int unsigned NPAGE      = 2,
  parameter int unsigned NREG       = 4,
  parameter int unsigned NSRAM      = 8,
  parameter int unsigned NBELL      = 3,
  parameter int unsigned BELL_OFS   = 'h800,
  parameter int unsigned SRAM_OFS   = 'h1000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_req,
  input  logic              host_we,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [DW-1:0]     host_wdata,
  output logic              host_ack,
  output logic [DW-1:0]     host_rdata
);
  localparam int unsigned PG_W   = (NPAGE > 1) ? $clog2(NPAGE) : 1;
  localparam int unsigned IX_A   = (NREG > NSRAM) ? NREG : NSRAM;
  localparam int unsigned IX_MAX = (IX_A > NBELL) ? IX_A : NBELL;
  localparam int unsigned IX_W   = (IX_MAX > 1) ? $clog2(IX_MAX) : 1;

  acc_kind_e          dec_kind;
  logic [PG_W-1:0]    dec_page;
  logic [IX_W-1:0]    dec_idx;
  logic [1:0]         dec_dw;
  logic               wr_en, rd_en, wide_we, sram_we, bell_we, ack_q;
  logic [WIDE_W-1:0]  wide_data, wide_rd;
  logic [SRAM_W-1:0]  sram_data, sram_rd;
  logic [DW-1:0]      bell_rd;
  logic [NSLOT-1:0]   stg_valid;
  logic [STAGE_W-1:0] stg_data;

  assign wr_en   = host_req && host_we;
  assign rd_en   = host_req && !host_we;
  assign bell_we = wr_en && (dec_kind == ACC_BELL);

  wrc_decode #(
    .ADDR_W(ADDR_W), .PAGE_SHIFT(PAGE_SHIFT), .NPAGE(NPAGE), .NREG(NREG),
    .NSRAM(NSRAM), .NBELL(NBELL), .BELL_OFS(BELL_OFS), .SRAM_OFS(SRAM_OFS),
    .PG_W(PG_W), .IX_W(IX_W)
  ) u_decode (
    .addr(host_addr), .kind(dec_kind), .page(dec_page), .idx(dec_idx), .dw(dec_dw)
  );

  wrc_stage #(.PG_W(PG_W), .IX_W(IX_W)) u_stage (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .kind(dec_kind), .page(dec_page),
    .idx(dec_idx), .dw(dec_dw), .wdata(host_wdata),
    .cur_wide_lo(wide_rd[STAGE_W-1:0]), .cur_sram_lo(sram_rd[DW-1:0]),
    .wide_we(wide_we), .sram_we(sram_we), .wide_data(wide_data),
    .sram_data(sram_data), .stg_valid(stg_valid), .stg_data(stg_data)
  );

  wrc_store #(
    .NPAGE(NPAGE), .NREG(NREG), .NSRAM(NSRAM), .NBELL(NBELL),
    .PG_W(PG_W), .IX_W(IX_W)
  ) u_store (
    .clk(clk), .rst_n(rst_n), .wide_we(wide_we), .sram_we(sram_we),
    .bell_we(bell_we), .page(dec_page), .idx(dec_idx),
    .wide_wdata(wide_data), .sram_wdata(sram_data), .bell_wdata(host_wdata),
    .wide_rd(wide_rd), .sram_rd(sram_rd), .bell_rd(bell_rd)
  );

  wrc_readpath u_read (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .kind(dec_kind), .dw(dec_dw),
    .wide_rd(wide_rd), .sram_rd(sram_rd), .bell_rd(bell_rd), .rdata(host_rdata)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ack_q <= 1'b0;
    else        ack_q <= host_req;
  end

  assign host_ack = ack_q;
endmodule

// File: rtl/wrc_checker.sv
`timescale 1ns/1ps
module wrc_checker
  import wrc_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic               host_req,
  input logic               host_we,
  input logic               host_ack,
  input logic [DW-1:0]      host_rdata,
  input acc_kind_e          dec_kind,
  input logic [1:0]         dec_dw,
  input logic               wide_we,
  input logic               sram_we,
  input logic               bell_we,
  input logic [NSLOT-1:0]   stg_valid,
  input logic [STAGE_W-1:0] stg_data
);
  a_r2_ack_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
    host_req |=> host_ack);

  a_r2_no_spurious_ack: assert property (@(posedge clk) disable iff (!rst_n)
    !host_req |=> !host_ack);

  a_r2_write_ack_zero_data: assert property (@(posedge clk) disable iff (!rst_n)
    host_req && host_we |=> host_rdata == '0);

  a_r3_commit_on_last_dword: assert property (@(posedge clk) disable iff (!rst_n)
    wide_we |-> host_req && host_we && dec_kind == ACC_WIDE && dec_dw == 2'd3);

  a_r3_stage_empty_after_commit: assert property (@(posedge clk) disable iff (!rst_n)
    wide_we || sram_we |=> stg_valid == '0);

  a_r4_sram_commit_on_upper: assert property (@(posedge clk) disable iff (!rst_n)
    sram_we |-> host_req && host_we && dec_kind == ACC_SRAM && dec_dw == 2'd1);

  a_r6_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({wide_we, sram_we, bell_we}));

  a_r7_bell_keeps_stage: assert property (@(posedge clk) disable iff (!rst_n)
    bell_we |=> $stable(stg_valid) && $stable(stg_data));

  a_r10_unmapped_keeps_stage: assert property (@(posedge clk) disable iff (!rst_n)
    host_req && dec_kind == ACC_NONE |=> $stable(stg_valid) && $stable(stg_data));
endmodule

bind wreg_collector wrc_checker u_chk (
  .clk(clk), .rst_n(rst_n), .host_req(host_req), .host_we(host_we),
  .host_ack(host_ack), .host_rdata(host_rdata), .dec_kind(dec_kind),
  .dec_dw(dec_dw), .wide_we(wide_we), .sram_we(sram_we), .bell_we(bell_we),
  .stg_valid(stg_valid), .stg_data(stg_data)
);

// File: tb/wreg_collector_tb.sv
`timescale 1ns/1ps
module wreg_collector_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        host_req, host_we;
  logic [15:0] host_addr;
  logic [31:0] host_wdata;
  logic        host_ack;
  logic [31:0] host_rdata;

  int    n_cmp = 0;
  int    n_bad = 0;
  string cur_req = "R1";
  string exp_tag = "R1";
  bit    started = 1'b0;
  bit    done = 1'b0;

  // behavioural reference state
  logic [127:0] m_wide [8];
  logic [63:0]  m_sram [8];
  logic [31:0]  m_bell [6];
  logic [127:0] m_shadow;
  logic [31:0]  st_d [3];
  bit           st_v [3];
  int           st_key;
  logic         exp_ack;
  logic [31:0]  exp_rdata;

  always #4 clk = ~clk;

  wreg_collector u_dut (
    .clk(clk), .rst_n(rst_n), .host_req(host_req), .host_we(host_we),
    .host_addr(host_addr), .host_wdata(host_wdata),
    .host_ack(host_ack), .host_rdata(host_rdata)
  );

  function automatic logic [15:0] wa(int pg, int r, int d);
    return 16'(pg * 'h2000 + r * 16 + d * 4);
  endfunction
  function automatic logic [15:0] sa(int i, int d);
    return 16'('h1000 + i * 8 + d * 4);
  endfunction
  function automatic logic [15:0] ba(int pg, int b);
    return 16'(pg * 'h2000 + 'h800 + b * 16);
  endfunction

  // address map from the requirements: 1 wide, 2 table entry, 3 doorbell, 0 unmapped
  task automatic mdec(input logic [15:0] a, output int kind, output int pg,
                      output int idx, output int d);
    int off;
    pg = int'(a) / 'h2000;
    off = int'(a) % 'h2000;
    kind = 0; idx = 0; d = 0;
    if (pg < 2) begin
      if (off < 64) begin
        kind = 1; idx = off / 16; d = (off % 16) / 4;
      end else if (off >= 'h800 && off < 'h830 && (off % 16) < 4) begin
        kind = 3; idx = (off - 'h800) / 16;
      end else if (pg == 0 && off >= 'h1000 && off < 'h1040) begin
        kind = 2; idx = (off - 'h1000) / 8; d = (off % 8) / 4;
      end
    end
  endtask

  always @(posedge clk) begin
    int kind, pg, idx, d, key;
    logic [127:0] nv;
    logic [63:0]  ns;
    if (!rst_n) begin
      for (int i = 0; i < 8; i++) begin m_wide[i] = '0; m_sram[i] = '0; end
      for (int i = 0; i < 6; i++) m_bell[i] = '0;
      for (int i = 0; i < 3; i++) begin st_v[i] = 1'b0; st_d[i] = '0; end
      m_shadow = '0; st_key = -1; exp_ack = 1'b0; exp_rdata = '0;
      exp_tag = "R1";
    end else begin
      exp_ack = host_req;
      exp_rdata = '0;
      exp_tag = cur_req;
      if (host_req) begin
        mdec(host_addr, kind, pg, idx, d);
        key = kind * 1000 + pg * 100 + idx;
        if (host_we) begin
          if ((kind == 1 && d < 3) || (kind == 2 && d == 0)) begin
            if (key != st_key) for (int i = 0; i < 3; i++) st_v[i] = 1'b0;
            st_key = key; st_d[d] = host_wdata; st_v[d] = 1'b1;
          end else if (kind == 1) begin
            nv = m_wide[pg * 4 + idx];
            for (int j = 0; j < 3; j++)
              if (st_key == key && st_v[j]) nv[j*32 +: 32] = st_d[j];
            nv[127:96] = host_wdata;
            m_wide[pg * 4 + idx] = nv;
            for (int i = 0; i < 3; i++) st_v[i] = 1'b0;
          end else if (kind == 2) begin
            ns = m_sram[idx];
            if (st_key == key && st_v[0]) ns[31:0] = st_d[0];
            ns[63:32] = host_wdata;
            m_sram[idx] = ns;
            for (int i = 0; i < 3; i++) st_v[i] = 1'b0;
          end else if (kind == 3) begin
            m_bell[pg * 3 + idx] = host_wdata;
          end
        end else begin
          if (kind == 1) begin
            if (d == 0) m_shadow = m_wide[pg * 4 + idx];
            exp_rdata = m_shadow[d*32 +: 32];
          end else if (kind == 2) begin
            if (d == 0) m_shadow[63:0] = m_sram[idx];
            exp_rdata = m_shadow[d*32 +: 32];
          end else if (kind == 3) begin
            exp_rdata = m_bell[pg * 3 + idx];
          end
        end
      end
    end
    started = 1'b1;
  end

  always @(negedge clk) begin
    if (started && !done) begin
      n_cmp++;
      if (host_ack !== exp_ack) begin
        n_bad++;
        $display("FAIL R2 (%s): host_ack actual=%0b expected=%0b", exp_tag, host_ack, exp_ack);
      end else if (host_rdata !== exp_rdata) begin
        n_bad++;
        $display("FAIL %s: host_rdata actual=%h expected=%h", exp_tag, host_rdata, exp_rdata);
      end
    end
  end

  task automatic wr(input logic [15:0] a, input logic [31:0] d);
    @(negedge clk);
    host_req = 1'b1; host_we = 1'b1; host_addr = a; host_wdata = d;
  endtask
  task automatic rd(input logic [15:0] a);
    @(negedge clk);
    host_req = 1'b1; host_we = 1'b0; host_addr = a; host_wdata = '0;
  endtask
  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      host_req = 1'b0; host_we = 1'b0;
    end
  endtask
  task automatic rd_wide(input int pg, input int r);
    for (int d = 0; d < 4; d++) rd(wa(pg, r, d));
  endtask
  task automatic summary;
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: run actual=hung expected=finished");
    summary();
    $finish;
  end

  initial begin
    rst_n = 1'b0; host_req = 1'b0; host_we = 1'b0; host_addr = '0; host_wdata = '0;
    // R1: outputs low during reset, storage zero afterwards
    cur_req = "R1";
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle(2);
    for (int r = 0; r < 4; r++) rd_wide(0, r);
    rd(sa(5, 0)); rd(sa(5, 1)); rd(ba(1, 2));
    idle(1);

    // R3: partial writes staged only, commit on dword 3
    cur_req = "R3";
    wr(wa(0, 1, 0), 32'h1111_0000); wr(wa(0, 1, 1), 32'h2222_0001);
    wr(wa(0, 1, 2), 32'h3333_0002);
    rd_wide(0, 1);
    wr(wa(0, 1, 3), 32'h4444_0003);
    rd_wide(0, 1);
    // R2: idle gap then back-to-back reads
    cur_req = "R2";
    idle(2);
    rd(wa(0, 1, 3)); rd(wa(0, 1, 0)); wr(wa(0, 0, 3), 32'h5); rd(wa(0, 0, 3));
    idle(1);

    // R4: buffer table entry
    cur_req = "R4";
    wr(sa(3, 0), 32'hAAAA_5555); rd(sa(3, 0)); rd(sa(3, 1));
    wr(sa(3, 1), 32'hBEEF_CAFE); rd(sa(3, 0)); rd(sa(3, 1));
    wr(sa(7, 0), 32'h7); wr(sa(7, 1), 32'h77); rd(sa(7, 0)); rd(sa(7, 1));

    // R5: shadow keeps the snapshot after a later commit
    cur_req = "R5";
    rd(wa(0, 1, 0));
    wr(wa(0, 1, 0), 32'hD0); wr(wa(0, 1, 1), 32'hD1); wr(wa(0, 1, 2), 32'hD2);
    wr(wa(0, 1, 3), 32'hD3);
    rd(wa(0, 1, 1)); rd(wa(0, 1, 2)); rd(wa(0, 1, 3));
    rd_wide(0, 1);

    // R6: doorbells
    cur_req = "R6";
    wr(ba(0, 1), 32'h0000_0042); rd(ba(0, 1));
    wr(ba(1, 0), 32'h0000_0099); rd(ba(1, 0)); rd(ba(0, 0));

    // R7: doorbell writes in the middle of a collection
    cur_req = "R7";
    wr(wa(0, 2, 0), 32'hC0C0_0000); wr(wa(0, 2, 1), 32'hC1C1_0000);
    wr(ba(0, 0), 32'h1); wr(ba(0, 2), 32'h2);
    wr(wa(0, 2, 2), 32'hC2C2_0000); wr(ba(1, 1), 32'h3);
    wr(wa(0, 2, 3), 32'hC3C3_0000);
    rd_wide(0, 2); rd(ba(0, 0)); rd(ba(0, 2)); rd(ba(1, 1));
    wr(sa(1, 0), 32'h5A5A); wr(ba(0, 1), 32'h9); wr(sa(1, 1), 32'hA5A5);
    rd(sa(1, 0)); rd(sa(1, 1));

    // R8: mismatched tag uses only dwords staged for the same target
    cur_req = "R8";
    wr(wa(0, 0, 0), 32'hE0); wr(wa(0, 0, 1), 32'hE1);
    wr(wa(0, 3, 1), 32'hF1);
    wr(wa(0, 0, 3), 32'hE3);
    rd_wide(0, 0);
    wr(wa(0, 3, 3), 32'hF3);
    rd_wide(0, 3);
    wr(wa(0, 2, 0), 32'h99); wr(sa(2, 1), 32'h12);
    rd(sa(2, 0)); rd(sa(2, 1)); rd_wide(0, 2);

    // R9: pages are separate storage
    cur_req = "R9";
    for (int d = 0; d < 4; d++) wr(wa(1, 1, d), 32'h9100 + d);
    rd_wide(1, 1); rd_wide(0, 1); rd_wide(1, 0);

    // R10: unmapped addresses
    cur_req = "R10";
    wr(wa(0, 1, 0), 32'h1234);
    wr(16'h0700, 32'hDEAD); wr(16'h3008, 32'hDEAD); wr(16'h0804, 32'hDEAD);
    wr(16'h4000, 32'hDEAD);
    wr(wa(0, 1, 3), 32'h5678);
    rd_wide(0, 1);
    rd(16'h0700); rd(16'h3008); rd(16'h0804); rd(16'h4000); rd(16'hFFFC);

    // mixed traffic
    for (int k = 0; k < 3000; k++) begin
      int sel;
      int pg;
      logic [15:0] a;
      logic [31:0] d;
      bit w;
      sel = int'($urandom % 7);
      pg  = int'($urandom % 2);
      w   = 1'($urandom % 2);
      d   = $urandom;
      case (sel)
        0, 1: begin a = wa(pg, int'($urandom % 4), int'($urandom % 4)); cur_req = w ? "R3" : "R5"; end
        2:    begin a = sa(int'($urandom % 8), int'($urandom % 2)); cur_req = "R4"; end
        3:    begin a = ba(pg, int'($urandom % 3)); cur_req = "R7"; end
        4:    begin a = wa(pg, int'($urandom % 4), 3); cur_req = "R8"; end
        5:    begin a = 16'($urandom); cur_req = "R10"; end
        default: begin a = wa(pg, int'($urandom % 4), int'($urandom % 3)); w = 1'b1; cur_req = "R3"; end
      endcase
      if (w) wr(a, d); else rd(a);
      if ($urandom % 8 == 0) idle(1);
    end
    idle(3);
    summary();
    $finish;
  end
endmodule